// File: doc/BRIEF.md
# Cell Voltage Protection Sequencer

This block supervises per-cell voltage for a multi-cell rechargeable pack. Analog comparators outside the block report, for each cell, whether it has crossed the overvoltage, second-level overvoltage, undervoltage and open-wire thresholds. They also report whether it sits back inside the release level for each of these. The block samples these bits once per monitor cycle and filters every condition through its own delay counter, counted in monitor cycles. From the result it raises charge-inhibit, discharge-inhibit and permanent-fail flags. Pin drivers downstream consume these flags.

The block also covers the power-up phase. Discharge is held off until the regulator reports good and every selected cell has reached the undervoltage release level. A two-bit selector sets how many cells are supervised. A test input shortens the monitor cycle and cuts every delay to one cycle. When a discharged pack has its charger removed, the block enters a low-power sleep. A charger-detect input wakes it again. The monitor cycle comes from a prescaler on the system clock.

Top module: `cellguard_seq`

## Requirements
- R1: After reset the block is in its initial state: `dsg_inhibit`=1, `chg_inhibit`=0, `perm_fail`=0. The block leaves this state on a monitor tick at which every selected cell shows `uv_rel`=1.
- R2: `mon_tick` pulses for one clock every PRESCALE clocks, or every PRESCALE_TEST clocks while `test_mode`=1. It stays low while `reg_ok`=0 or while `power_down`=1.
- R3: `chg_inhibit` rises at the tick that delivers the DLY_OV-th sample with any selected cell showing `ov_hit`=1.
- R4: A sample with no selected overvoltage hit clears the overvoltage count only if the previous sample also had no hit. A single clean sample holds the count.
- R5: An overvoltage is released at the first tick on which every selected cell shows `ov_rel`=1. A hit that has gone away while some `ov_rel` is still 0 keeps `chg_inhibit` high.
- R6: `perm_fail` rises at the DLY_SOV-th `sov_hit` sample, using the same two-clean-sample clear rule. It falls at a tick with all selected `sov_rel`=1. It does not affect `chg_inhibit`.
- R7: `dsg_inhibit` rises at the DLY_UV-th `uv_hit` sample and falls at a tick with all selected `uv_rel`=1.
- R8: Open-wire is declared at the DLY_OW-th `ow_hit` sample and sets `chg_inhibit`. A single clean sample clears the detection count.
- R9: Open-wire releases only after DLY_OW consecutive samples with no selected `ow_hit`. Any hit restarts that count.
- R10: `cell_sel` sets which cells are supervised. 00 supervises cells 0..4. 01 ignores cell 0. 1x ignores cells 0 and 1. Cell 0 is the lowest cell in the stack.
- R11: While undervoltage is flagged and no second-level overvoltage is latched, `pullup_en`=1. In that state `chg_removed`=1 sets `power_down` on the next clock. With `perm_fail`=1, neither the pull-up nor power-down occurs.
- R12: In power-down, `dsg_inhibit`=1 and the overvoltage and undervoltage flags are cleared. `chg_detect`=1 clears `power_down` on the next clock.
- R13: With `test_mode`=1, every detection delay is one monitor cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_ok | input | 1 | Regulator above its good level |
| test_mode | input | 1 | Shortened cycle and one-cycle delays |
| cell_sel | input | 2 | Cell-count select |
| ov_hit | input | N_CELLS | Cell at or above overvoltage threshold |
| ov_rel | input | N_CELLS | Cell at or below overvoltage release level |
| sov_hit | input | N_CELLS | Cell at or above second-level overvoltage threshold |
| sov_rel | input | N_CELLS | Cell at or below second-level release level |
| uv_hit | input | N_CELLS | Cell at or below undervoltage threshold |
| uv_rel | input | N_CELLS | Cell at or above undervoltage release level |
| ow_hit | input | N_CELLS | Cell at or below open-wire threshold |
| chg_removed | input | 1 | Charger-removal comparator |
| chg_detect | input | 1 | Charger-connection comparator |
| mon_tick | output | 1 | Monitor-cycle strobe |
| chg_inhibit | output | 1 | Charge not permitted |
| dsg_inhibit | output | 1 | Discharge not permitted |
| perm_fail | output | 1 | Second-level overvoltage latched |
| pullup_en | output | 1 | Enable sense-line pull-up |
| power_down | output | 1 | Sleep state |

## Verification
The overvoltage filter is driven with three patterns. The first is an unbroken run of hits, which fixes the exact detection tick. The second has hits broken by one clean sample; it must reach detection on the accumulated count. The third is broken by two clean samples and must start counting again from zero. Together these separate the two-sample clear from a one-sample clear and from no clear at all. Open-wire gets the matching one-sample pattern, plus a release run interrupted by a single hit. Cell-select is tried with faults on the ignored cells, then with the same fault on a supervised cell. Power-down entry is tried both with a second-level overvoltage latched and without one.

// File: rtl/cg_pkg.sv
package cg_pkg;
   // width of a counter that must hold values 0..max_val
   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/cg_prescaler.sv
module cg_prescaler #(
   parameter int DIV   = 400,
   parameter int DIV_T = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic tick
);
   localparam int PW = cg_pkg::cnt_width(DIV);

   generate
      if (DIV_T < 1 || DIV_T > DIV) begin : g_bad_div
         $error("cg_prescaler: DIV_T must lie in 1..DIV");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] lim;

   assign lim  = fast ? PW'(DIV_T - 1) : PW'(DIV - 1);
   assign tick = run & (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (tick)   cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cg_cell_mask.sv
module cg_cell_mask #(
   parameter int N_CELLS = 5
) (
   input  logic [1:0]         sel,
   output logic [N_CELLS-1:0] mask
);
   logic [1:0] drop;
   assign drop = sel[1] ? 2'd2 : (sel[0] ? 2'd1 : 2'd0);

   generate
      for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
         if (i >= 2) begin : g_fixed
            assign mask[i] = 1'b1;
         end else begin : g_sel
            assign mask[i] = (drop <= 2'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/cg_dly_filter.sv
module cg_dly_filter #(
   parameter int CW       = 5,
   parameter bit TWO_GOOD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic          bad,
   input  logic [CW-1:0] limit,
   output logic          fire
);
   logic [CW-1:0] cnt_q;
   logic [CW:0]   nxt;

   assign nxt  = {1'b0, cnt_q} + 1'b1;
   assign fire = en & tick & bad & (nxt >= {1'b0, limit});

   generate
      if (TWO_GOOD) begin : g_two
         logic streak_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q    <= '0;
               streak_q <= 1'b0;
            end else if (!en) begin
               cnt_q    <= '0;
               streak_q <= 1'b0;
            end else if (tick) begin
               if (bad) begin
                  streak_q <= 1'b0;
                  if (!fire) cnt_q <= nxt[CW-1:0];
               end else begin
                  streak_q <= 1'b1;
                  if (streak_q) cnt_q <= '0;
               end
            end
         end
      end else begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (!en)      cnt_q <= '0;
            else if (tick) begin
               if (!bad)       cnt_q <= '0;
               else if (!fire) cnt_q <= nxt[CW-1:0];
            end
         end
      end
   endgenerate

   // R3
   handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !en);
endmodule

// File: rtl/cellguard_seq.sv
module cellguard_seq #(
   parameter int N_CELLS       = 5,
   parameter int PRESCALE      = 400,
   parameter int PRESCALE_TEST = 100,
   parameter int DLY_OV        = 5,
   parameter int DLY_SOV       = 20,
   parameter int DLY_UV        = 5,
   parameter int DLY_OW        = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_ok,
   input  logic               test_mode,
   input  logic [1:0]         cell_sel,
   input  logic [N_CELLS-1:0] ov_hit,
   input  logic [N_CELLS-1:0] ov_rel,
   input  logic [N_CELLS-1:0] sov_hit,
   input  logic [N_CELLS-1:0] sov_rel,
   input  logic [N_CELLS-1:0] uv_hit,
   input  logic [N_CELLS-1:0] uv_rel,
   input  logic [N_CELLS-1:0] ow_hit,
   input  logic               chg_removed,
   input  logic               chg_detect,
   output logic               mon_tick,
   output logic               chg_inhibit,
   output logic               dsg_inhibit,
   output logic               perm_fail,
   output logic               pullup_en,
   output logic               power_down
);
   localparam int DMAX = cg_pkg::max3(cg_pkg::max3(DLY_OV, DLY_SOV, DLY_UV), DLY_OW, 1);
   localparam int CW   = cg_pkg::cnt_width(DMAX);

   generate
      if (N_CELLS < 3) begin : g_bad_cells
         $error("cellguard_seq: at least three cells are required");
      end
      if (DLY_OV < 1 || DLY_SOV < 1 || DLY_UV < 1 || DLY_OW < 1) begin : g_bad_dly
         $error("cellguard_seq: every delay must be at least one cycle");
      end
   endgenerate

   logic init_q, ov_q, sov_q, uv_q, ow_q, pd_q;
   logic [N_CELLS-1:0] act;
   logic any_ov, any_sov, any_uv, any_ow;
   logic all_ov_rel, all_sov_rel, all_uv_rel;
   logic ov_fire, sov_fire, uv_fire, owd_fire, owr_fire;
   logic [CW-1:0] lim_ov, lim_sov, lim_uv, lim_ow;

   cg_prescaler #(.DIV(PRESCALE), .DIV_T(PRESCALE_TEST)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(reg_ok & ~pd_q), .fast(test_mode), .tick(mon_tick));

   cg_cell_mask #(.N_CELLS(N_CELLS)) u_mask (.sel(cell_sel), .mask(act));

   assign any_ov      = |(ov_hit  & act);
   assign any_sov     = |(sov_hit & act);
   assign any_uv      = |(uv_hit  & act);
   assign any_ow      = |(ow_hit  & act);
   assign all_ov_rel  = &(ov_rel  | ~act);
   assign all_sov_rel = &(sov_rel | ~act);
   assign all_uv_rel  = &(uv_rel  | ~act);

   assign lim_ov  = test_mode ? CW'(1) : CW'(DLY_OV);
   assign lim_sov = test_mode ? CW'(1) : CW'(DLY_SOV);
   assign lim_uv  = test_mode ? CW'(1) : CW'(DLY_UV);
   assign lim_ow  = test_mode ? CW'(1) : CW'(DLY_OW);

   cg_dly_filter #(.CW(CW), .TWO_GOOD(1'b1)) u_f_ov (
      .clk(clk), .rst_n(rst_n), .tick(mon_tick), .en(~ov_q & ~pd_q),
      .bad(any_ov), .limit(lim_ov), .fire(ov_fire));

   cg_dly_filter #(.CW(CW), .TWO_GOOD(1'b1)) u_f_sov (
      .clk(clk), .rst_n(rst_n), .tick(mon_tick), .en(~sov_q & ~pd_q),
      .bad(any_sov), .limit(lim_sov), .fire(sov_fire));

   cg_dly_filter #(.CW(CW), .TWO_GOOD(1'b1)) u_f_uv (
      .clk(clk), .rst_n(rst_n), .tick(mon_tick), .en(~uv_q & ~pd_q),
      .bad(any_uv), .limit(lim_uv), .fire(uv_fire));

   cg_dly_filter #(.CW(CW), .TWO_GOOD(1'b0)) u_f_owd (
      .clk(clk), .rst_n(rst_n), .tick(mon_tick), .en(~ow_q & ~pd_q),
      .bad(any_ow), .limit(lim_ow), .fire(owd_fire));

   cg_dly_filter #(.CW(CW), .TWO_GOOD(1'b0)) u_f_owr (
      .clk(clk), .rst_n(rst_n), .tick(mon_tick), .en(ow_q & ~pd_q),
      .bad(~any_ow), .limit(lim_ow), .fire(owr_fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b1;
         ov_q   <= 1'b0;
         sov_q  <= 1'b0;
         uv_q   <= 1'b0;
         ow_q   <= 1'b0;
         pd_q   <= 1'b0;
      end else if (pd_q) begin
         ov_q <= 1'b0;
         uv_q <= 1'b0;
         if (chg_detect) pd_q <= 1'b0;
      end else begin
         if (mon_tick) begin
            if (init_q && all_uv_rel) init_q <= 1'b0;
            if (ov_fire)                  ov_q <= 1'b1;
            else if (ov_q && all_ov_rel)  ov_q <= 1'b0;
            if (sov_fire)                 sov_q <= 1'b1;
            else if (sov_q && all_sov_rel) sov_q <= 1'b0;
            if (uv_fire)                  uv_q <= 1'b1;
            else if (uv_q && all_uv_rel)  uv_q <= 1'b0;
            if (owd_fire)                 ow_q <= 1'b1;
            else if (owr_fire)            ow_q <= 1'b0;
         end
         if (uv_q && !sov_q && chg_removed) pd_q <= 1'b1;
      end
   end

   assign chg_inhibit = ov_q | ow_q;
   assign dsg_inhibit = init_q | uv_q | pd_q;
   assign perm_fail   = sov_q;
   assign pullup_en   = (uv_q | pd_q) & ~sov_q;
   assign power_down  = pd_q;

   // R11
   pd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sov_q |-> !pd_q);

   // R6
   sov_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_tick |=> $stable(sov_q));

   // R12
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_q && !chg_detect) |=> pd_q);

   // R1
   init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init_q) |-> $past(mon_tick));
endmodule

// File: tb/sim_cellguard_seq.sv
module sim_cellguard_seq;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 5;
   localparam int PS = 8;
   localparam int PT = 2;

   logic clk = 1'b0;
   logic rst_n, reg_ok, test_mode, chg_removed, chg_detect;
   logic [1:0] cell_sel;
   logic [N-1:0] ov_hit, ov_rel, sov_hit, sov_rel, uv_hit, uv_rel, ow_hit;
   logic mon_tick, chg_inhibit, dsg_inhibit, perm_fail, pullup_en, power_down;

   int checks = 0;
   int errors = 0;
   int tick_seen = 0;
   logic finished = 1'b0;

   // expected model {chg, dsg, pf, pu, pd}
   logic e_chg, e_dsg, e_pf, e_pu, e_pd;
   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cellguard_seq #(.N_CELLS(N), .PRESCALE(PS), .PRESCALE_TEST(PT)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_ok(reg_ok), .test_mode(test_mode),
      .cell_sel(cell_sel), .ov_hit(ov_hit), .ov_rel(ov_rel),
      .sov_hit(sov_hit), .sov_rel(sov_rel), .uv_hit(uv_hit), .uv_rel(uv_rel),
      .ow_hit(ow_hit), .chg_removed(chg_removed), .chg_detect(chg_detect),
      .mon_tick(mon_tick), .chg_inhibit(chg_inhibit), .dsg_inhibit(dsg_inhibit),
      .perm_fail(perm_fail), .pullup_en(pullup_en), .power_down(power_down));

   always @(negedge clk) if (mon_tick) tick_seen++;

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         logic [4:0] e, a;
         string t;
         wait (exp_q.size() != 0);
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {chg_inhibit, dsg_inhibit, perm_fail, pullup_en, power_down};
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s: {chg,dsg,pf,pu,pd} actual %b expected %b at %0t", t, a, e, $time);
         end
      end
   end

   task automatic expect_out(input string t);
      exp_q.push_back({e_chg, e_dsg, e_pf, e_pu, e_pd});
      tag_q.push_back(t);
      #1;
   endtask

   task automatic chk_int(input string t, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", t, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!mon_tick) @(negedge clk);
         @(posedge clk);
         #1;
      end
   endtask

   task automatic measure_period(output int n);
      @(negedge clk);
      while (!mon_tick) @(negedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!mon_tick);
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual run still going, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int per, t0;
      rst_n = 1'b0; reg_ok = 1'b0; test_mode = 1'b0; cell_sel = 2'b01;
      chg_removed = 1'b0; chg_detect = 1'b0;
      ov_hit = '0; ov_rel = '1; sov_hit = '0; sov_rel = '1;
      uv_hit = '0; uv_rel = 5'b11110; ow_hit = '0;
      e_chg = 0; e_dsg = 1; e_pf = 0; e_pu = 0; e_pd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      // R1 reset / initial state
      expect_out("R1 initial state");
      // R2 no tick while regulator low
      chk_int("R2 ticks with reg_ok low", tick_seen, 0);

      reg_ok = 1'b1;
      uv_rel = 5'b11100;           // supervised cell 1 still low
      step(2);
      expect_out("R1 stays initial until release level");
      uv_rel = 5'b11110;           // only ignored cell 0 low (R10)
      step(1);
      e_dsg = 0;
      expect_out("R1 exit to normal, R10 cell 0 ignored");
      measure_period(per);
      chk_int("R2 normal period", per, PS);

      // R3 detection timing
      ov_hit = 5'b10000; ov_rel = 5'b01111;
      step(4);
      expect_out("R3 no detect after 4 samples");
      step(1);
      e_chg = 1;
      expect_out("R3 detect at 5th sample");
      // R5 hysteresis
      ov_hit = '0;
      step(2);
      expect_out("R5 held while release not reached");
      ov_rel = '1;
      step(1);
      e_chg = 0;
      expect_out("R5 release");

      // R4 one clean sample does not clear
      ov_hit = 5'b01000; ov_rel = 5'b10111;
      step(3);
      ov_hit = '0;
      step(1);
      ov_hit = 5'b01000;
      step(1);
      expect_out("R4 count held, 4 samples");
      step(1);
      e_chg = 1;
      expect_out("R4 count held, detect at 5th");
      ov_hit = '0; ov_rel = '1;
      step(1);
      e_chg = 0;
      expect_out("R5 release after R4 pattern");
      // R4 two clean samples clear
      ov_hit = 5'b01000; ov_rel = 5'b10111;
      step(3);
      ov_hit = '0;
      step(2);
      ov_hit = 5'b01000;
      step(4);
      expect_out("R4 count cleared by two clean samples");
      step(1);
      e_chg = 1;
      expect_out("R4 detect after restart");
      ov_hit = '0; ov_rel = '1;
      step(1);
      e_chg = 0;
      expect_out("R5 release again");

      // R10 cell select
      cell_sel = 2'b01; ov_hit = 5'b00001; ov_rel = 5'b11110;
      step(6);
      expect_out("R10 sel 01 ignores cell 0");
      cell_sel = 2'b00;
      step(4);
      expect_out("R10 sel 00 counting cell 0");
      step(1);
      e_chg = 1;
      expect_out("R10 sel 00 supervises cell 0");
      ov_hit = '0; ov_rel = '1;
      step(1);
      e_chg = 0;
      expect_out("R5 release cell 0");
      cell_sel = 2'b10; uv_hit = 5'b00010; uv_rel = 5'b11101;
      step(6);
      expect_out("R10 sel 1x ignores cell 1");
      uv_hit = '0; uv_rel = '1; cell_sel = 2'b00;

      // R6 second-level overvoltage
      sov_hit = 5'b00100; sov_rel = 5'b11011;
      step(19);
      expect_out("R6 no permanent fail after 19");
      step(1);
      e_pf = 1;
      expect_out("R6 permanent fail at 20th");

      // R7 / R11 undervoltage with permanent fail latched
      uv_hit = 5'b00100; uv_rel = 5'b11011;
      step(4);
      expect_out("R7 no undervoltage after 4");
      step(1);
      e_dsg = 1;
      expect_out("R7 undervoltage, R11 no pull-up while latched");
      chg_removed = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      expect_out("R11 power-down blocked by permanent fail");
      sov_hit = '0; sov_rel = '1;
      step(1);
      e_pf = 0; e_pu = 1;
      expect_out("R6 release, R11 pull-up enabled");
      @(posedge clk); #1;
      e_pd = 1;
      expect_out("R11 power-down entry");
      chg_removed = 1'b0;
      t0 = tick_seen;
      repeat (40) @(negedge clk);
      chk_int("R2 no tick in power-down", tick_seen, t0);
      expect_out("R12 power-down held without wake");
      // R12 wake
      chg_detect = 1'b1;
      @(posedge clk); #1;
      chg_detect = 1'b0;
      e_pd = 0; e_pu = 0; e_dsg = 0;
      expect_out("R12 wake with undervoltage flag cleared");
      step(4);
      expect_out("R12 redetect pending");
      step(1);
      e_dsg = 1; e_pu = 1;
      expect_out("R7 redetect after wake");
      uv_hit = '0; uv_rel = '1;
      step(1);
      e_dsg = 0; e_pu = 0;
      expect_out("R7 undervoltage release");

      // R8 open-wire detection, one-sample clear
      ow_hit = 5'b01000;
      step(4);
      ow_hit = '0;
      step(1);
      ow_hit = 5'b01000;
      step(8);
      expect_out("R8 single clean sample cleared count");
      step(1);
      e_chg = 1;
      expect_out("R8 open-wire detect");
      // R9 delayed release with restart
      ow_hit = '0;
      step(8);
      expect_out("R9 release not yet after 8");
      ow_hit = 5'b01000;
      step(1);
      ow_hit = '0;
      step(8);
      expect_out("R9 release count restarted");
      step(1);
      e_chg = 0;
      expect_out("R9 open-wire release");

      // R13 test mode
      test_mode = 1'b1;
      measure_period(per);
      chk_int("R13 test period", per, PT);
      ov_hit = 5'b10000; ov_rel = 5'b01111;
      step(1);
      e_chg = 1;
      expect_out("R13 overvoltage in one cycle");
      uv_hit = 5'b00001; uv_rel = 5'b11110;
      step(1);
      e_dsg = 1; e_pu = 1;
      expect_out("R13 undervoltage in one cycle");

      wait (exp_q.size() == 0);
      #1;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule